// File: doc/BRIEF.md
# Internal Data Memory Unit for an 8051-Family Core

This unit sits between an 8051-family execution core and its internal data space. It resolves every access into one of three stores: the lower 128 bytes of a 256-byte internal RAM, the upper 128 bytes of that RAM, or an external special-function-register file. The SFR file is reached through a simple bus port. The core presents several things with each access:

- an 8-bit address;
- a flag that selects direct or indirect addressing;
- a flag that marks a bit operation;
- a flag that asks for a working-register access;
- the 2-bit register-bank select, taken from bits 4:3 of the status word;
- a 3-bit register index.

Reads are combinational. Writes take effect on the rising clock edge.

Addresses 0x80 to 0xFF are shared. An indirect access reaches the upper RAM. A direct access reaches the SFR port. For a bit operation, the address field carries a bit address. The unit maps that bit address onto a bit-addressable RAM byte or onto a bit-addressable SFR. It then performs a read-modify-write within a single cycle, so only the selected bit changes. RAM contents are undefined after reset, and software must initialise them.

Top module: `idata_unit`

## Requirements
- R1: Byte addresses 0x00 to 0x7F reach the same RAM byte whether the access is direct or indirect.
- R2: An indirect byte access to 0x80 to 0xFF reaches the upper RAM, and the SFR write strobe stays low.
- R3: A direct byte access to 0x80 to 0xFF goes to the SFR port. On a write, `sfrWe` is 1, `sfrAddr` equals the address and `sfrWdata` equals the data. On a read, `rdData` equals `sfrRdata`. The upper RAM byte at that address is left unchanged.
- R4: A register access (`useReg`=1) reaches RAM byte bankSel*8 + regIdx.
- R5: Bit addresses 0x00 to 0x7F select RAM byte 0x20 + (bitaddr >> 3), bit position bitaddr[2:0]. `bitOut` returns that bit and `rdData` returns the whole byte.
- R6: Bit addresses 0x80 to 0xFF select SFR byte (bitaddr & 0xF8), bit position bitaddr[2:0]. A bit write drives `sfrWe`=1 and sets `sfrWdata` to `sfrRdata` with only that bit replaced by `bitIn`.
- R7: A bit write changes only the selected bit of the target byte. The other seven bits keep their values.
- R8: Indirect accesses form one continuous 256-byte space. Bytes 0x7F and 0x80 are distinct neighbours and both are stored in RAM.
- R9: A bit operation issued with indirect addressing or as a register access raises `badBit` and writes nothing.
- R10: Nothing is written unless `accEn`, `wrEn` and `rstN` are all high at the clock edge. `rdData` follows the address in the same cycle, and during a write it shows the old value until the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; blocks writes |
| accEn | input | 1 | Access valid this cycle |
| wrEn | input | 1 | Access is a write |
| modeInd | input | 1 | 1 = indirect addressing, 0 = direct |
| bitOp | input | 1 | Access is a bit operation; `addr` is a bit address |
| useReg | input | 1 | Working-register access via bank and index |
| bankSel | input | 2 | Active register bank |
| regIdx | input | 3 | Register index within bank |
| addr | input | 8 | Byte or bit address |
| wrData | input | 8 | Byte write data |
| bitIn | input | 1 | Bit write value |
| rdData | output | 8 | Selected byte |
| bitOut | output | 1 | Selected bit of the selected byte |
| badBit | output | 1 | Illegal bit operation flag |
| sfrAddr | output | 8 | SFR byte address |
| sfrWe | output | 1 | SFR write strobe |
| sfrWdata | output | 8 | SFR write data |
| sfrRdata | input | 8 | SFR read data, combinational |

## Verification
Within one cycle, a bit write reads the target byte and writes the merged byte back, while the same byte is also on the read path. The bench provokes this by holding a bit write on a known byte. It samples `rdData` and `bitOut` before the edge, where they must still show the old byte, and `sfrWdata`, which must already show the merged byte. It then reads the byte after the edge and expects only the chosen bit to have moved. A direct and an indirect access to the same upper address are interleaved, which shows that RAM and SFR contents never leak into each other.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int BANK_W    = 2;
  localparam int IDX_W     = 3;
  localparam int POS_W     = $clog2(DATA_W);
  localparam int RAM_BYTES = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BIT_BASE = 8'h20;

  typedef struct packed {
    logic              ramWe;
    logic              sfrWe;
    logic              selSfr;
    logic              bitOp;
    logic [POS_W-1:0]  bitPos;
    logic [ADDR_W-1:0] byteAddr;
  } idStrobe_t;
endpackage

// File: rtl/idata_ctrl.sv
module idata_ctrl
  import idata_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accEn,
  input  logic              wrEn,
  input  logic              modeInd,
  input  logic              bitOp,
  input  logic              useReg,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] addr,
  output idStrobe_t         stb,
  output logic              badBit
);
  localparam int SHIFT_W = ADDR_W - 1 - POS_W;

  logic illegal;
  logic writeOk;

  always_comb begin
    illegal  = accEn && bitOp && (modeInd || useReg);
    writeOk  = accEn && wrEn && rstN && !illegal;
    stb      = '0;
    stb.bitPos = addr[POS_W-1:0];
    if (useReg) begin
      stb.byteAddr = {{(ADDR_W-BANK_W-IDX_W){1'b0}}, bankSel, regIdx};
      stb.selSfr   = 1'b0;
    end else if (bitOp) begin
      stb.bitOp = !illegal;
      if (!addr[ADDR_W-1]) begin
        stb.byteAddr = BIT_BASE + {{(ADDR_W-SHIFT_W){1'b0}}, addr[ADDR_W-2:POS_W]};
        stb.selSfr   = 1'b0;
      end else begin
        stb.byteAddr = {addr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        stb.selSfr   = !modeInd;
      end
    end else begin
      stb.byteAddr = addr;
      stb.selSfr   = addr[ADDR_W-1] && !modeInd;
    end
    stb.ramWe = writeOk && !stb.selSfr;
    stb.sfrWe = writeOk && stb.selSfr;
    badBit    = illegal;
  end

  // R9
  bad_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    badBit |-> !(stb.ramWe || stb.sfrWe));

  // R10
  dual_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ramWe && stb.sfrWe));

  // R2
  ind_ram_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && modeInd && !useReg) |-> !stb.selSfr);

  // R4
  reg_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && useReg) |-> (stb.byteAddr[ADDR_W-1:BANK_W+IDX_W] == '0));
endmodule

// File: rtl/idata_dp.sv
module idata_dp
  import idata_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  idStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitIn,
  input  logic [DATA_W-1:0] sfrRdata,
  output logic [DATA_W-1:0] rdData,
  output logic              bitOut,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic              sfrWe,
  output logic [DATA_W-1:0] sfrWdata
);
  logic [DATA_W-1:0] mem [RAM_BYTES];
  logic [DATA_W-1:0] curByte;
  logic [DATA_W-1:0] mergedByte;
  logic [DATA_W-1:0] newByte;

  always_comb begin
    curByte = stb.selSfr ? sfrRdata : mem[stb.byteAddr];
    mergedByte = curByte;
    mergedByte[stb.bitPos] = bitIn;
    newByte = stb.bitOp ? mergedByte : wrData;
  end

  always_ff @(posedge clk) begin
    if (stb.ramWe) mem[stb.byteAddr] <= newByte;
  end

  assign rdData   = curByte;
  assign bitOut   = curByte[stb.bitPos];
  assign sfrAddr  = stb.byteAddr;
  assign sfrWe    = stb.sfrWe;
  assign sfrWdata = newByte;

  // R7
  bit_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.ramWe || stb.sfrWe) && stb.bitOp) |->
      (((newByte ^ curByte) & ~(DATA_W'(1) << stb.bitPos)) == '0));

  // R3
  sfr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    sfrWe |-> sfrAddr[ADDR_W-1]);

  // R6
  sfr_bitalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWe && stb.bitOp) |-> (sfrAddr[POS_W-1:0] == '0));
endmodule

// File: rtl/idata_unit.sv
module idata_unit
  import idata_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accEn,
  input  logic              wrEn,
  input  logic              modeInd,
  input  logic              bitOp,
  input  logic              useReg,
  input  logic [1:0]        bankSel,
  input  logic [2:0]        regIdx,
  input  logic [7:0]        addr,
  input  logic [7:0]        wrData,
  input  logic              bitIn,
  output logic [7:0]        rdData,
  output logic              bitOut,
  output logic              badBit,
  output logic [7:0]        sfrAddr,
  output logic              sfrWe,
  output logic [7:0]        sfrWdata,
  input  logic [7:0]        sfrRdata
);
  idStrobe_t stb;

  idata_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accEn(accEn), .wrEn(wrEn), .modeInd(modeInd),
    .bitOp(bitOp), .useReg(useReg), .bankSel(bankSel), .regIdx(regIdx),
    .addr(addr), .stb(stb), .badBit(badBit)
  );

  idata_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .bitIn(bitIn),
    .sfrRdata(sfrRdata), .rdData(rdData), .bitOut(bitOut),
    .sfrAddr(sfrAddr), .sfrWe(sfrWe), .sfrWdata(sfrWdata)
  );
endmodule

// File: tb/sim_idata_unit.sv
module sim_idata_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accEn = 1'b0, wrEn = 1'b0, modeInd = 1'b0, bitOp = 1'b0, useReg = 1'b0;
  logic [1:0] bankSel = '0;
  logic [2:0] regIdx = '0;
  logic [7:0] addr = '0, wrData = '0;
  logic bitIn = 1'b0;
  logic [7:0] rdData, sfrAddr, sfrWdata, sfrRdata;
  logic bitOut, badBit, sfrWe;
  logic [7:0] sfrMem [256];
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idata_unit u0 (
    .clk(clk), .rstN(rstN), .accEn(accEn), .wrEn(wrEn), .modeInd(modeInd),
    .bitOp(bitOp), .useReg(useReg), .bankSel(bankSel), .regIdx(regIdx),
    .addr(addr), .wrData(wrData), .bitIn(bitIn), .rdData(rdData),
    .bitOut(bitOut), .badBit(badBit), .sfrAddr(sfrAddr), .sfrWe(sfrWe),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata)
  );

  assign sfrRdata = sfrMem[sfrAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) sfrMem[i] <= 8'(i);
    end else if (sfrWe) begin
      sfrMem[sfrAddr] <= sfrWdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic ind, input logic bo, input logic ur,
                       input logic [1:0] bk, input logic [2:0] ri,
                       input logic [7:0] a, input logic [7:0] d, input logic bi);
    @(negedge clk);
    accEn = 1'b1; wrEn = wr; modeInd = ind; bitOp = bo; useReg = ur;
    bankSel = bk; regIdx = ri; addr = a; wrData = d; bitIn = bi;
    #2;
  endtask

  task automatic finish();
    @(negedge clk);
    accEn = 1'b0; wrEn = 1'b0; modeInd = 1'b0; bitOp = 1'b0; useReg = 1'b0;
  endtask

  task automatic wrByte(input logic [7:0] a, input logic [7:0] d, input logic ind);
    drive(1'b1, ind, 1'b0, 1'b0, 2'd0, 3'd0, a, d, 1'b0);
    finish();
  endtask

  task automatic rdByte(input logic [7:0] a, input logic ind, output logic [7:0] v);
    drive(1'b0, ind, 1'b0, 1'b0, 2'd0, 3'd0, a, 8'h00, 1'b0);
    v = rdData;
    finish();
  endtask

  task automatic initRam();
    for (int i = 0; i < 256; i++) wrByte(8'(i), 8'(i) ^ 8'h5A, 1'b1);
  endtask

  task automatic testReset();
    logic [7:0] v;
    @(negedge clk); rstN = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 8'h90, 8'hEE, 1'b0);
    finish();
    rstN = 1'b1;
    rdByte(8'h90, 1'b1, v);
    chk(v == 8'hCA, "R10 write blocked in reset", v, 8'hCA);
    chk(!sfrWe && !badBit, "R10 idle strobes", {6'd0, sfrWe, badBit}, 8'h00);
  endtask

  task automatic testLowRam();
    logic [7:0] v;
    wrByte(8'h45, 8'hA1, 1'b0);
    rdByte(8'h45, 1'b1, v);
    chk(v == 8'hA1, "R1 direct wr indirect rd", v, 8'hA1);
    wrByte(8'h30, 8'h3C, 1'b1);
    rdByte(8'h30, 1'b0, v);
    chk(v == 8'h3C, "R1 indirect wr direct rd", v, 8'h3C);
  endtask

  task automatic testUpperIndirect();
    logic [7:0] v;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 8'hC3, 8'h77, 1'b0);
    chk(!sfrWe, "R2 no sfr strobe", {7'd0, sfrWe}, 8'h00);
    finish();
    rdByte(8'hC3, 1'b1, v);
    chk(v == 8'h77, "R2 upper ram readback", v, 8'h77);
  endtask

  task automatic testSfrDirect();
    logic [7:0] v;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 8'hC3, 8'h99, 1'b0);
    chk(sfrWe && sfrAddr == 8'hC3 && sfrWdata == 8'h99, "R3 sfr write port", sfrWdata, 8'h99);
    finish();
    rdByte(8'hC3, 1'b0, v);
    chk(v == 8'h99, "R3 sfr read", v, 8'h99);
    rdByte(8'hC3, 1'b1, v);
    chk(v == 8'h77, "R3 upper ram untouched", v, 8'h77);
  endtask

  task automatic testRegBanks();
    logic [7:0] v;
    for (int b = 0; b < 4; b++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b1, 2'(b), 3'd5, 8'h00, 8'h10 + 8'(b), 1'b0);
      finish();
    end
    for (int b = 0; b < 4; b++) begin
      rdByte(8'(b * 8 + 5), 1'b0, v);
      chk(v == 8'h10 + 8'(b), "R4 bank mapping", v, 8'h10 + 8'(b));
    end
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 3'd5, 8'h00, 8'h00, 1'b0);
    v = rdData;
    finish();
    chk(v == 8'h12, "R4 register read", v, 8'h12);
  endtask

  task automatic testRamBits();
    logic [7:0] v;
    wrByte(8'h2A, 8'h00, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 8'h53, 8'h00, 1'b1);
    chk(rdData == 8'h00 && !bitOut, "R5 old byte before edge", rdData, 8'h00);
    finish();
    rdByte(8'h2A, 1'b0, v);
    chk(v == 8'h08, "R5 bit set in byte 2A", v, 8'h08);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 8'h53, 8'h00, 1'b0);
    chk(bitOut == 1'b1, "R5 bit read", {7'd0, bitOut}, 8'h01);
    finish();
    wrByte(8'h2F, 8'hFF, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 8'h7F, 8'h00, 1'b0);
    finish();
    rdByte(8'h2F, 1'b0, v);
    chk(v == 8'h7F, "R7 only bit 7 cleared", v, 8'h7F);
  endtask

  task automatic testSfrBits();
    logic [7:0] v;
    wrByte(8'hA8, 8'h81, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 8'hAD, 8'h00, 1'b1);
    chk(sfrWe && sfrAddr == 8'hA8 && sfrWdata == 8'hA1, "R6 sfr bit merge", sfrWdata, 8'hA1);
    chk(rdData == 8'h81, "R6 old sfr byte before edge", rdData, 8'h81);
    finish();
    rdByte(8'hA8, 1'b0, v);
    chk(v == 8'hA1, "R6 sfr byte after", v, 8'hA1);
  endtask

  task automatic testContig();
    logic [7:0] v;
    wrByte(8'h7F, 8'h11, 1'b1);
    wrByte(8'h80, 8'h22, 1'b1);
    rdByte(8'h7F, 1'b1, v);
    chk(v == 8'h11, "R8 byte 7F", v, 8'h11);
    rdByte(8'h80, 1'b1, v);
    chk(v == 8'h22, "R8 byte 80", v, 8'h22);
  endtask

  task automatic testBadBit();
    logic [7:0] v;
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 8'h53, 8'h00, 1'b0);
    chk(badBit && !sfrWe, "R9 indirect bit flagged", {7'd0, badBit}, 8'h01);
    finish();
    rdByte(8'h2A, 1'b0, v);
    chk(v == 8'h08, "R9 no write", v, 8'h08);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 3'd2, 8'h00, 8'h00, 1'b1);
    chk(badBit, "R9 register bit flagged", {7'd0, badBit}, 8'h01);
    finish();
    rdByte(8'h0A, 1'b0, v);
    chk(v == (8'h0A ^ 8'h5A), "R9 register unchanged", v, 8'h0A ^ 8'h5A);
  endtask

  task automatic testReadComb();
    logic [7:0] v;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 8'hE0, 8'h3D, 1'b0);
    chk(rdData == (8'hE0 ^ 8'h5A), "R10 old value during write", rdData, 8'hE0 ^ 8'h5A);
    finish();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 8'hE0, 8'h00, 1'b0);
    accEn = 1'b0;
    finish();
    rdByte(8'hE0, 1'b1, v);
    chk(v == 8'h3D, "R10 no write without accEn", v, 8'h3D);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    initRam();
    testReset();
    testLowRam();
    testUpperIndirect();
    testSfrDirect();
    testRegBanks();
    testRamBits();
    testSfrBits();
    testContig();
    testBadBit();
    testReadComb();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule